// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an 8-bit general-purpose I/O port on a simple register bus. Software uses three registers. The data register holds the values to drive. The direction register chooses, bit by bit, whether a pin drives or listens. The set register forces chosen data bits to one in a single write, without a read-modify-write over the bus. Each pin has three outputs: an output value, an output-enable and a pull-up enable. Each pin has one input, the raw pin level.

Raw pin levels pass through a two-stage synchronizer before they are used. A read of the data register is assembled bit by bit. Bits set as outputs return the stored value. Bits set as inputs return the synchronized pin level.

Stored data bits accept every write, whatever their direction. A value written while a pin listens appears on that pin as soon as its direction bit turns it into an output. After reset every pin is an undriven input and every pull-up is off.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the stored data and direction bits clear to zero. After that edge, `pin_oe`, `pin_out` and `pin_pu` are all zero.
- R2: `pin_oe[i]` equals direction bit i, and `pin_out[i]` equals stored data bit i, at all times.
- R3: A read at address 0 returns, for each bit i, stored data bit i when direction bit i is 1, and synchronized pin level i when direction bit i is 0.
- R4: A write at address 0 replaces all eight stored data bits, including bits whose direction is input. Such a bit drives its new value once its direction bit becomes 1.
- R5: A write at address 2 sets to 1 each stored data bit whose written bit is 1. It leaves every other data bit, and the direction bits, unchanged.
- R6: A read at address 2 or address 3 returns 0. A write at address 3 changes neither the data bits nor the direction bits.
- R7: A write at address 1 loads the direction bits. A read at address 1 returns them.
- R8: A pin change sampled at rising edge k shows in address-0 read data after edge k+1. It does not show after edge k alone.
- R9: `pin_pu` stays zero in every cycle.
- R10: `bus_rdata` is zero in every cycle where `bus_rd` is low. When `bus_rd` is high, it is valid in that same cycle.
- R11: If a read and a write happen in the same cycle, the read returns the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 set, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output-enable |
| pin_pu | output | 8 | Per-pin pull-up enable |

## Verification
Assertions check the following on every clock:
- each data, direction and set write has the right effect on the stored bits in the next cycle;
- cycles without a write, and writes to the unused address, leave the stored bits unchanged;
- reset clears the stored bits;
- the synchronizer output is exactly the pin level from two edges earlier;
- read data for bits set as outputs matches `pin_out`.

Only the bench scenarios show behaviour that spans several operations:
- a value written while a bit is an input, then driven after the direction changes;
- the exact two-clock lag seen through the bus;
- read-before-write ordering within one cycle;
- randomized mixes of reads and writes checked against the register model.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_DATA = 2'd0,
    ADR_DIR  = 2'd1,
    ADR_SET  = 2'd2,
    ADR_NONE = 2'd3
  } gp_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];

  // Counts clean edges since reset, saturating at two, so the lag check
  // never looks back into the reset period.
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  if (STAGES == 2) begin : g_lag_chk
    // R8: the synchronized level is the raw level from two edges earlier
    p_sync_lag_r8: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd2) |-> (sync_out == $past(async_in, 2)));
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pu_q
);
  gp_addr_e sel;
  assign sel = gp_addr_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (wr) begin
      unique case (sel)
        ADR_DATA: data_q <= wdata;
        ADR_DIR:  dir_q  <= wdata;
        ADR_SET:  data_q <= data_q | wdata;
        ADR_NONE: ;
      endcase
    end
  end

  // Pull-ups exist as registered enables with no write path: always off.
  always_ff @(posedge clk) begin
    if (rst) pu_q <= '0;
    else     pu_q <= '0;
  end

  // R1: reset clears stored state
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (data_q == '0 && dir_q == '0 && pu_q == '0));

  // R4: a data write lands in every bit
  p_data_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == ADR_DATA) |=> (data_q == $past(wdata)));

  // R5: set write raises written ones and keeps all prior ones
  p_set_ones_r5: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == ADR_SET) |=>
      (((data_q & $past(wdata)) == $past(wdata)) &&
       ((data_q & $past(data_q)) == $past(data_q)) &&
       ((data_q & ~($past(data_q) | $past(wdata))) == '0) &&
       $stable(dir_q)));

  // R7: direction write loads direction bits
  p_dir_write_r7: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == ADR_DIR) |=> (dir_q == $past(wdata) && $stable(data_q)));

  // R6: no write, or a write to the unused slot, leaves state unchanged
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr || sel == ADR_NONE) |=> ($stable(data_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_port_readback.sv
module gpio_port_readback
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  data_q,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] port_view;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign port_view[b] = dir_q[b] ? data_q[b] : pin_sync[b];
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (gp_addr_e'(addr))
        ADR_DATA: rdata = port_view;
        ADR_DIR:  rdata = dir_q;
        ADR_SET:  rdata = '0;
        ADR_NONE: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_pu
);
  logic [WIDTH-1:0] data_q, dir_q, pu_q, pin_sync;

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .data_q(data_q), .dir_q(dir_q), .pu_q(pu_q)
  );

  gpio_port_readback #(.WIDTH(WIDTH)) u_rb (
    .rd(bus_rd), .addr(bus_addr), .data_q(data_q), .dir_q(dir_q),
    .pin_sync(pin_sync), .rdata(bus_rdata)
  );

  assign pin_out = data_q;
  assign pin_oe  = dir_q;
  assign pin_pu  = pu_q;

  // R3: output bits read back what the pins are driven with
  p_read_out_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADR_DATA) |-> (((bus_rdata ^ pin_out) & pin_oe) == '0));

  // R9: pull-ups never enabled once out of reset
  p_pullup_off_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) == 1'b0 |-> (pin_pu == '0 && $stable(pin_pu)));

  // R10: idle bus returns zero
  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, pin_in = '0;
  logic [7:0] bus_rdata, pin_out, pin_oe, pin_pu;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [7:0] m_data = '0, m_dir = '0, m_s1 = '0, m_s2 = '0;

  always #10 clk = ~clk;

  gpio_port_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return (m_data & m_dir) | (m_s2 & ~m_dir);
      2'd1:    return m_dir;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one clock edge; model follows the bus signals present at that edge
  task automatic step();
    @(posedge clk);
    m_s2 = m_s1;
    m_s1 = pin_in;
    if (rst) begin
      m_data = '0; m_dir = '0; m_s1 = '0; m_s2 = '0;
    end else if (bus_wr) begin
      case (bus_addr)
        2'd0: m_data = bus_wdata;
        2'd1: m_dir  = bus_wdata;
        2'd2: m_data = m_data | bus_wdata;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(req, bus_rdata, exp_read(a));
    bus_rd = 1'b0;
    #1;
  endtask

  task automatic pins_chk(input string req);
    check({req, " oe"}, pin_oe, m_dir);
    check({req, " out"}, pin_out, m_data);
    check({req, " pu"}, pin_pu, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd1234));
    @(negedge clk);
    pin_in = 8'hA5;
    step(); step(); step();
    // R1: reset state
    pins_chk("R1");
    rst = 1'b0;
    step();
    rd_chk("R1 dir", 2'd1);
    // R10: idle read bus is zero
    #1 check("R10 idle", bus_rdata, 8'h00);

    // R8: lag of exactly two edges
    pin_in = 8'h3C;
    step();
    rd_chk("R8 one edge", 2'd0);   // still old level
    step();
    check("R8 old", exp_read(2'd0), 8'h3C);
    rd_chk("R8 two edges", 2'd0);

    // R4: write while all inputs, then turn outputs on
    wr(2'd0, 8'h5A);
    pins_chk("R4 stored");
    rd_chk("R4 still pins", 2'd0);
    wr(2'd1, 8'h0F);
    pins_chk("R4 driven");
    rd_chk("R3 mixed", 2'd0);
    rd_chk("R7 dir", 2'd1);

    // R5: set alias
    wr(2'd2, 8'h81);
    check("R5 set", pin_out, 8'hDB);
    wr(2'd2, 8'h00);
    check("R5 zero set", pin_out, 8'hDB);
    rd_chk("R6 set reads 0", 2'd2);

    // R6: unused slot
    wr(2'd3, 8'hFF);
    pins_chk("R6 unused write");
    rd_chk("R6 unused read", 2'd3);

    // R11: read and write same cycle returns old value
    bus_addr = 2'd1; bus_wdata = 8'hF0; bus_wr = 1'b1; bus_rd = 1'b1;
    #1 check("R11 rd-before-wr", bus_rdata, 8'h0F);
    step();
    rd_chk("R11 after", 2'd1);
    pins_chk("R2 after dir");

    // random mix
    for (int i = 0; i < 400; i++) begin
      r = 8'($urandom);
      if (r[7:6] == 2'b00) pin_in = 8'($urandom);
      if (r[0]) begin
        if (r[1] && r[2]) begin
          bus_addr = r[4:3]; bus_wdata = 8'($urandom); bus_wr = 1'b1; bus_rd = 1'b1;
          #1 check("R11 rand", bus_rdata, exp_read(bus_addr));
          step();
        end else begin
          wr(r[4:3], 8'($urandom));
        end
      end else begin
        rd_chk("R3 rand", r[4:3]);
        step();
      end
      pins_chk("R2 rand");
    end

    // reset mid-run clears everything
    rst = 1'b1;
    step();
    rst = 1'b0;
    pins_chk("R1 rerun");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule